// File: doc/BRIEF.md
# Streaming Top-K Nearest-Neighbour Vote Unit

This block sits after a similarity engine in a nearest-neighbour classifier. For one test item it takes in a stream of (score, class label) pairs, one per training item, where a larger score means the training item is closer. It keeps the K largest scores seen so far in a small register array. The array is held in ascending order, so position 0 always holds the weakest survivor.

Most incoming scores do not beat the weakest survivor. The block compares each new score against position 0 only, and throws it away after that one compare unless it is strictly larger. A score that is strictly larger overwrites position 0. It then moves up the array by one position per cycle for as long as it strictly exceeds its upper neighbour. While it moves, the input stream is stalled.

When the pair flagged as last has been absorbed, the block adds up the surviving scores for each class. It then scans the classes and reports the class with the largest total, together with that total. After that it clears the array for the next test item.

Top module: `knn_topk_classifier`

## Requirements
- R1: At the start of every stream (after reset and after each result) all K slots hold score 0 with label 0. The result reflects exactly the K largest scores of the stream. When equal scores compete for the last place, the one that arrived first is kept.
- R2: Whenever the block is accepting input, slot scores are non-decreasing from position 0 to position K-1.
- R3: An accepted score that is less than or equal to the score at position 0 is discarded, and it leaves every slot unchanged. A score of 0 is therefore never retained.
- R4: An accepted score strictly greater than position 0 replaces position 0. It then swaps upward one position per clock while it strictly exceeds the next slot, and it never passes an equal score. `in_ready` is low from the cycle after such an acceptance until the move ends.
- R5: After the pair with `in_last`=1 has been absorbed, `res_valid` pulses high for exactly one cycle. `res_class` carries the class label (the 5-bit `in_label` value, unsigned) whose retained scores have the largest total, and `res_sum` carries that total.
- R6: When two or more classes share the largest total, the lowest label wins. When every retained score is 0, the result is class 0 with sum 0.
- R7: `in_ready` stays low from the cycle after the last pair is accepted until the cycle after the result pulse. The next stream then starts from the cleared state of R1.
- R8: `in_ready` is high after reset, and `res_valid` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A score/label pair is offered |
| in_ready | output | 1 | The block takes the offered pair at this clock edge |
| in_score | input | SCORE_W (32) | Unsigned similarity score; larger is closer |
| in_label | input | LABEL_W (5) | Class of the training item |
| in_last | input | 1 | Marks the final pair of the stream |
| res_valid | output | 1 | One-cycle pulse carrying the result |
| res_class | output | LABEL_W (5) | Winning class label |
| res_sum | output | SCORE_W+clog2(K+1) | Total of the winning class's retained scores |

## Verification
The bench shrinks the block to K=4, 2-bit labels and 8-bit scores, so that ties and evictions are frequent. Short fixed streams each isolate one behaviour:
- a stream of all zeros separates the empty-result rule from normal voting;
- two classes with equal totals expose the tie rule;
- rising and falling runs longer than K separate correct eviction of the weakest slot from eviction of the wrong one;
- runs of equal scores at the cut-off show whether the first arrival is kept.

A few hundred random streams of lengths 1 to 12, with scores drawn from a narrow range, are then checked against a full stable sort computed in the bench. The handshake is also probed directly: it must stall after a score that enters the array, and it must not stall after a score that is discarded.

// File: rtl/knn_topk_pkg.sv
package knn_topk_pkg;

    typedef enum logic [1:0] {
        INS_ACCEPT,
        INS_BUBBLE,
        INS_HOLD
    } ins_state_e;

    typedef enum logic [1:0] {
        TAL_IDLE,
        TAL_SUM,
        TAL_PICK
    } tal_state_e;

endpackage

// File: rtl/topk_insert.sv
module topk_insert
    import knn_topk_pkg::*;
#(
    parameter int K       = 30,
    parameter int SCORE_W = 32,
    parameter int LABEL_W = 5,
    localparam int IDX_W  = (K > 1) ? $clog2(K) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [SCORE_W-1:0] in_score,
    input  logic [LABEL_W-1:0] in_label,
    input  logic               in_last,
    input  logic               clear,
    output logic               done,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [SCORE_W-1:0] rd_score,
    output logic [LABEL_W-1:0] rd_label
);

    typedef struct packed {
        logic [SCORE_W-1:0] score;
        logic [LABEL_W-1:0] label;
    } slot_t;

    typedef struct packed {
        ins_state_e      state;
        logic [IDX_W-1:0] pos;
        logic            last;
        logic            done;
        slot_t [K-1:0]   slots;
    } ins_reg_t;

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(K - 1);

    ins_reg_t r_q, r_d;
    logic fire;
    logic [IDX_W-1:0] up;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        fire     = in_valid && (r_q.state == INS_ACCEPT);
        up       = (r_q.pos == TOP_IDX) ? r_q.pos : r_q.pos + 1'b1;
        case (r_q.state)
            INS_ACCEPT: begin
                if (fire) begin
                    if (in_score > r_q.slots[0].score) begin
                        r_d.slots[0].score = in_score;
                        r_d.slots[0].label = in_label;
                        r_d.pos            = '0;
                        r_d.last           = in_last;
                        r_d.state          = INS_BUBBLE;
                    end else if (in_last) begin
                        r_d.state = INS_HOLD;
                        r_d.done  = 1'b1;
                    end
                end
            end
            INS_BUBBLE: begin
                if (r_q.pos != TOP_IDX &&
                    r_q.slots[r_q.pos].score > r_q.slots[up].score) begin
                    r_d.slots[r_q.pos] = r_q.slots[up];
                    r_d.slots[up]      = r_q.slots[r_q.pos];
                    r_d.pos            = up;
                end else if (r_q.last) begin
                    r_d.state = INS_HOLD;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.state = INS_ACCEPT;
                end
            end
            INS_HOLD: begin
                if (clear) begin
                    r_d.slots = '0;
                    r_d.last  = 1'b0;
                    r_d.state = INS_ACCEPT;
                end
            end
            default: r_d.state = INS_ACCEPT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= INS_ACCEPT;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready = (r_q.state == INS_ACCEPT);
    assign done     = r_q.done;
    assign rd_score = r_q.slots[rd_idx].score;
    assign rd_label = r_q.slots[rd_idx].label;

    for (genvar i = 0; i < K - 1; i++) begin : g_order
        assert_sorted_R2: assert property (@(posedge clk) disable iff (!rst_n)
            r_q.state == INS_ACCEPT |-> r_q.slots[i].score <= r_q.slots[i+1].score);
    end

    assert_drop_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_score <= r_q.slots[0].score) |=> $stable(r_q.slots));

    assert_stall_on_insert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_score > r_q.slots[0].score) |=> !in_ready);

    assert_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && r_q.state == INS_HOLD) |=> (r_q.slots[0].score == '0 && in_ready));

endmodule

// File: rtl/class_tally.sv
module class_tally
    import knn_topk_pkg::*;
#(
    parameter int K       = 30,
    parameter int SCORE_W = 32,
    parameter int LABEL_W = 5,
    parameter int SUM_W   = 37,
    localparam int IDX_W  = (K > 1) ? $clog2(K) : 1,
    localparam int NCLS   = 1 << LABEL_W,
    localparam int CNT_W  = (IDX_W > LABEL_W) ? IDX_W : LABEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic [IDX_W-1:0]   rd_idx,
    input  logic [SCORE_W-1:0] rd_score,
    input  logic [LABEL_W-1:0] rd_label,
    output logic               clear,
    output logic               res_valid,
    output logic [LABEL_W-1:0] res_class,
    output logic [SUM_W-1:0]   res_sum
);

    typedef struct packed {
        tal_state_e                    state;
        logic [CNT_W-1:0]              cnt;
        logic [NCLS-1:0][SUM_W-1:0]    sums;
        logic [LABEL_W-1:0]            best_cls;
        logic [SUM_W-1:0]              best_sum;
        logic                          res_valid;
        logic [LABEL_W-1:0]            res_class;
        logic [SUM_W-1:0]              res_sum;
        logic                          clear;
    } tal_reg_t;

    tal_reg_t t_q, t_d;
    logic [SUM_W-1:0]   cand;
    logic [SUM_W-1:0]   nb_sum;
    logic [LABEL_W-1:0] nb_cls;

    always_comb begin
        t_d           = t_q;
        t_d.res_valid = 1'b0;
        t_d.clear     = 1'b0;
        rd_idx        = t_q.cnt[IDX_W-1:0];
        cand          = t_q.sums[t_q.cnt[LABEL_W-1:0]];
        nb_sum        = t_q.best_sum;
        nb_cls        = t_q.best_cls;
        if (cand > t_q.best_sum) begin
            nb_sum = cand;
            nb_cls = t_q.cnt[LABEL_W-1:0];
        end
        case (t_q.state)
            TAL_IDLE: begin
                if (start) begin
                    t_d.state = TAL_SUM;
                    t_d.cnt   = '0;
                end
            end
            TAL_SUM: begin
                t_d.sums[rd_label] = t_q.sums[rd_label] + SUM_W'(rd_score);
                if (t_q.cnt == CNT_W'(K - 1)) begin
                    t_d.state    = TAL_PICK;
                    t_d.cnt      = '0;
                    t_d.best_cls = '0;
                    t_d.best_sum = '0;
                end else begin
                    t_d.cnt = t_q.cnt + 1'b1;
                end
            end
            TAL_PICK: begin
                t_d.best_sum = nb_sum;
                t_d.best_cls = nb_cls;
                if (t_q.cnt == CNT_W'(NCLS - 1)) begin
                    t_d.res_valid = 1'b1;
                    t_d.res_class = nb_cls;
                    t_d.res_sum   = nb_sum;
                    t_d.sums      = '0;
                    t_d.clear     = 1'b1;
                    t_d.state     = TAL_IDLE;
                end else begin
                    t_d.cnt = t_q.cnt + 1'b1;
                end
            end
            default: t_d.state = TAL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q       <= '0;
            t_q.state <= TAL_IDLE;
        end else begin
            t_q <= t_d;
        end
    end

    assign clear     = t_q.clear;
    assign res_valid = t_q.res_valid;
    assign res_class = t_q.res_class;
    assign res_sum   = t_q.res_sum;

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_empty_class0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_sum == '0) |-> res_class == '0);

    assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> t_q.state == TAL_IDLE);

endmodule

// File: rtl/knn_topk_classifier.sv
module knn_topk_classifier
    import knn_topk_pkg::*;
#(
    parameter int K       = 30,
    parameter int SCORE_W = 32,
    parameter int LABEL_W = 5,
    localparam int SUM_W  = SCORE_W + $clog2(K + 1),
    localparam int IDX_W  = (K > 1) ? $clog2(K) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [SCORE_W-1:0] in_score,
    input  logic [LABEL_W-1:0] in_label,
    input  logic               in_last,
    output logic               res_valid,
    output logic [LABEL_W-1:0] res_class,
    output logic [SUM_W-1:0]   res_sum
);

    logic               ins_done;
    logic               tal_clear;
    logic [IDX_W-1:0]   rd_idx;
    logic [SCORE_W-1:0] rd_score;
    logic [LABEL_W-1:0] rd_label;

    topk_insert #(.K(K), .SCORE_W(SCORE_W), .LABEL_W(LABEL_W)) u_insert (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_score (in_score),
        .in_label (in_label),
        .in_last  (in_last),
        .clear    (tal_clear),
        .done     (ins_done),
        .rd_idx   (rd_idx),
        .rd_score (rd_score),
        .rd_label (rd_label)
    );

    class_tally #(.K(K), .SCORE_W(SCORE_W), .LABEL_W(LABEL_W), .SUM_W(SUM_W)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ins_done),
        .rd_idx    (rd_idx),
        .rd_score  (rd_score),
        .rd_label  (rd_label),
        .clear     (tal_clear),
        .res_valid (res_valid),
        .res_class (res_class),
        .res_sum   (res_sum)
    );

    assert_no_result_while_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !in_ready);

endmodule

// File: tb/knn_topk_classifier_test.sv
module knn_topk_classifier_test;

    localparam int K  = 4;
    localparam int SW = 8;
    localparam int LW = 2;
    localparam int SUMW = SW + $clog2(K + 1);
    localparam int NC = 1 << LW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [SW-1:0]   in_score = '0;
    logic [LW-1:0]   in_label = '0;
    logic            in_last = 1'b0;
    logic            res_valid;
    logic [LW-1:0]   res_class;
    logic [SUMW-1:0] res_sum;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int st_sc[16];
    int st_lb[16];
    int st_n;

    always #2 clk = ~clk;

    knn_topk_classifier #(.K(K), .SCORE_W(SW), .LABEL_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_score(in_score), .in_label(in_label), .in_last(in_last),
        .res_valid(res_valid), .res_class(res_class), .res_sum(res_sum)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // drive at a falling edge, hold until accepted, return at the next falling edge
    task automatic send(input int sc, input int lb, input bit last);
        bit ok;
        in_valid = 1'b1;
        in_score = SW'(sc);
        in_label = LW'(lb);
        in_last  = last;
        forever begin
            ok = in_ready;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic get_result(output int cls, output int sum);
        int n = 0;
        cls = -1;
        sum = -1;
        while (!res_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(res_valid, "R5 result timeout", n, 400);
        cls = int'(res_class);
        sum = int'(res_sum);
        @(negedge clk);
        check(!res_valid, "R5 one-cycle pulse", int'(res_valid), 0);
    endtask

    // reference: stable selection of the K largest nonzero scores
    task automatic reference(output int cls, output int sum);
        bit used[16];
        int sums[NC];
        for (int i = 0; i < 16; i++) used[i] = 1'b0;
        for (int c = 0; c < NC; c++) sums[c] = 0;
        for (int k = 0; k < K; k++) begin
            int bi = -1;
            for (int i = 0; i < st_n; i++)
                if (!used[i] && st_sc[i] > 0 && (bi < 0 || st_sc[i] > st_sc[bi])) bi = i;
            if (bi >= 0) begin
                used[bi] = 1'b1;
                sums[st_lb[bi]] += st_sc[bi];
            end
        end
        cls = 0;
        sum = sums[0];
        for (int c = 1; c < NC; c++)
            if (sums[c] > sum) begin
                cls = c;
                sum = sums[c];
            end
    endtask

    task automatic run_stream(input string tag);
        int ac, as, ec, es;
        for (int i = 0; i < st_n; i++) send(st_sc[i], st_lb[i], i == st_n - 1);
        get_result(ac, as);
        reference(ec, es);
        check(ac == ec, {tag, " class"}, ac, ec);
        check(as == es, {tag, " sum"}, as, es);
    endtask

    task automatic set2(input int i, input int sc, input int lb);
        st_sc[i] = sc;
        st_lb[i] = lb;
    endtask

    initial begin
        int ac, as;
        repeat (3) @(negedge clk);
        // R8: state after reset
        check(in_ready == 1'b1, "R8 ready after reset", int'(in_ready), 1);
        check(res_valid == 1'b0, "R8 no result after reset", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 stall after an inserted score, R3 no stall after a dropped one
        send(9, 1, 1'b0);
        check(in_ready == 1'b0, "R4 stall while moving", int'(in_ready), 0);
        while (!in_ready) @(negedge clk);
        send(0, 2, 1'b0);
        check(in_ready == 1'b1, "R3 zero dropped without stall", int'(in_ready), 1);
        send(9, 2, 1'b1);
        // R7: closed until the result
        check(in_ready == 1'b0, "R7 ready low after last", int'(in_ready), 0);
        get_result(ac, as);
        check(ac == 1 && as == 9, "R6 tie 9 vs 9 lowest label", ac * 1000 + as, 1009);

        // R1 example: 3,3,0,0 all class 0
        st_n = 4; set2(0, 3, 0); set2(1, 3, 0); set2(2, 0, 1); set2(3, 0, 1);
        run_stream("R1 basic");
        // R6: all zeros gives class 0 sum 0
        st_n = 3; set2(0, 0, 3); set2(1, 0, 2); set2(2, 0, 1);
        run_stream("R6 all zero");
        // R6: tie between classes 3 and 2
        st_n = 2; set2(0, 5, 3); set2(1, 5, 2);
        run_stream("R6 class tie");
        // R1 eviction on a rising run (top 4 of 1..6)
        st_n = 6;
        for (int i = 0; i < 6; i++) set2(i, i + 1, i % NC);
        run_stream("R1 rising evict");
        // R1 falling run
        for (int i = 0; i < 6; i++) set2(i, 60 - 10 * i, (i + 1) % NC);
        run_stream("R1 falling evict");
        // R4 equal scores: first arrivals kept (class 1 gets 28, class 2 nothing)
        st_n = 6;
        for (int i = 0; i < 4; i++) set2(i, 7, 1);
        set2(4, 7, 2); set2(5, 7, 2);
        run_stream("R4 equal keep first");
        // R3 equal to smallest dropped
        st_n = 5;
        set2(0, 4, 0); set2(1, 4, 0); set2(2, 4, 0); set2(3, 4, 3); set2(4, 4, 3);
        run_stream("R3 equal dropped");
        // R2/R5 random streams against the stable reference
        for (int t = 0; t < 300; t++) begin
            st_n = $urandom_range(1, 12);
            for (int i = 0; i < st_n; i++)
                set2(i, $urandom_range(0, (t % 3 == 0) ? 6 : 255), $urandom_range(0, NC - 1));
            run_stream("R5 random");
        end
        // R8 single last pair with max score
        st_n = 1; set2(0, 255, 3);
        run_stream("R8 single max");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule